// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clocks of a small 8-bit controller are running. It has three operating modes. In run mode everything is clocked. In idle mode the CPU clock is gated off while the peripheral clock and the oscillator keep going. In power-down mode the oscillator and every clock derived from it are stopped. Software asks for idle or power-down with one-cycle request pulses. A pending enabled interrupt ends idle. Only the external reset pin can end power-down.

The reset pin works on two levels. As soon as it is high, the block forces the port latches to ones. A real internal reset is issued only after the pin has stayed high for two 12-clock machine cycles while the oscillator runs. If the pin is raised during power-down, the oscillator is switched back on first. An oscillator-stabilise count and the reset qualification count then run side by side, and the internal reset waits for both. When the internal reset starts, a one-cycle strobe tells the register file to reload its default values: stack pointer 0x07, port latches 0xFF, and 0x00 for the other control registers. Working RAM sits outside the block and is never cleared by it.

The sequencer itself runs on an always-on reference clock. The `osc_en` output is the request that gates the core oscillator.

Top module: `pwr_mode_seq`

## Requirements
- R1: After the synchronous `rst`, the block is in run mode: `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `core_rst` and `sfr_load` are 0.
- R2: An `idle_req` pulse in run mode clears `cpu_clk_en` from the next cycle, while `per_clk_en` and `osc_en` stay 1.
- R3: In idle, `irq_pend` high at a clock edge sets `cpu_clk_en` back to 1 in the cycle after that edge.
- R4: A `pd_req` pulse in run mode clears `cpu_clk_en`, `per_clk_en` and `osc_en` from the next cycle. `irq_pend` has no effect in power-down.
- R5: If `idle_req` and `pd_req` are high in the same run-mode cycle, power-down is entered.
- R6: `port_force_hi` is 1 in every cycle in which `rst_pin` is 1 or `core_rst` is 1, with no qualification delay.
- R7: Outside power-down, `core_rst` rises in the cycle after the 24th consecutive edge (RST_MCYCLES=2 times CLKS_PER_MC=12) at which `rst_pin` is sampled high. A shorter high pulse leaves all outputs except `port_force_hi` unchanged.
- R8: `sfr_load` is high for exactly one cycle, which is the first cycle of `core_rst`.
- R9: `core_rst` stays high, with `cpu_clk_en` and `per_clk_en` on, for as long as `rst_pin` is high. It is removed and run mode resumes one edge after `rst_pin` is sampled low.
- R10: In power-down, `rst_pin` high at an edge sets `osc_en` in the next cycle, with the CPU and peripheral clocks still off. `core_rst` follows once both OSC_STAB_CLKS (40) and 24 wake-up edges have passed with the pin high. If the pin falls earlier, the block returns to power-down.
- R11: A qualified reset also ends idle mode and enters the internal reset.
- R12: `idle_req` and `pd_req` pulses arriving while the block is in idle have no effect.

Mode encoding used by the requirements: run, idle, power-down, wake-up and reset are internal modes. They are seen only through the output pattern (cpu, per, osc, core_rst): run 1,1,1,0; idle 0,1,1,0; power-down 0,0,0,0; wake-up 0,0,1,0; reset 1,1,1,1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| idle_req | input | 1 | Software request pulse to enter idle |
| pd_req | input | 1 | Software request pulse to enter power-down |
| irq_pend | input | 1 | A pending enabled interrupt |
| rst_pin | input | 1 | External reset pin, already synchronised |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Timer, serial and interrupt clock gate enable |
| osc_en | output | 1 | Core oscillator enable |
| core_rst | output | 1 | Qualified internal reset |
| sfr_load | output | 1 | One-cycle strobe reloading register defaults |
| port_force_hi | output | 1 | Immediate drive of port latches to ones |

## Verification
The sequencer is tried with several input patterns:
- An idle entry that an interrupt ends, which separates the two clock gates.
- Simultaneous idle and power-down requests, which expose the priority.
- Interrupts and requests sent into power-down and idle, which must leave no trace.
- Reset pulses one cycle shorter than the qualification window and longer than it, which locate the exact edge of qualification.
- A pin raised during power-down, dropped early and then held long, which separates the stabilise count from the qualification count and shows the return to power-down.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        M_RUN   = 3'd0,
        M_IDLE  = 3'd1,
        M_PDOWN = 3'd2,
        M_WAKE  = 3'd3,
        M_RESET = 3'd4
    } pms_mode_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic rst;
    } pms_gate_t;

    // Register defaults the strobe reloads (consumed by the register file)
    localparam logic [7:0] SP_DEFAULT   = 8'h07;
    localparam logic [7:0] PORT_DEFAULT = 8'hFF;
    localparam logic [7:0] CTRL_DEFAULT = 8'h00;

    function automatic pms_gate_t gate_of(pms_mode_e m);
        pms_gate_t g;
        case (m)
            M_RUN:   g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, rst: 1'b0};
            M_IDLE:  g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, rst: 1'b0};
            M_PDOWN: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, rst: 1'b0};
            M_WAKE:  g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, rst: 1'b0};
            M_RESET: g = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, rst: 1'b1};
            default: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, rst: 1'b0};
        endcase
        return g;
    endfunction

    function automatic logic osc_stopped(pms_mode_e m);
        return (m == M_PDOWN);
    endfunction

endpackage

// File: rtl/pms_sat_cnt.sv
module pms_sat_cnt #(
    parameter int MAX = 23
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic full
);
    localparam int W = (MAX < 1) ? 1 : $clog2(MAX + 1);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign full = (cnt_q == LIMIT);

    // the counter saturates and never passes its limit (R7, R10)
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

endmodule

// File: rtl/pms_rst_qual.sv
module pms_rst_qual
    import pms_pkg::*;
#(
    parameter int RST_CLKS = 24
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rst_pin,
    input  pms_mode_e mode,
    output logic      qual_done
);
    logic full;
    logic clear;

    // counting needs a running oscillator and an unbroken high pin
    assign clear = !rst_pin || osc_stopped(mode);

    pms_sat_cnt #(.MAX(RST_CLKS - 1)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(clear),
        .inc  (1'b1),
        .full (full)
    );

    assign qual_done = rst_pin && full;

    // a qualified reset implies the pin was already high one edge ago (R7)
    assert_qual_history_R7: assert property (@(posedge clk) disable iff (rst)
        qual_done |-> $past(rst_pin));

endmodule

// File: rtl/pms_osc_wait.sv
module pms_osc_wait
    import pms_pkg::*;
#(
    parameter int STAB_CLKS = 40
) (
    input  logic      clk,
    input  logic      rst,
    input  pms_mode_e mode,
    output logic      stab_done
);
    logic full;
    logic in_wake;

    assign in_wake = (mode == M_WAKE);

    pms_sat_cnt #(.MAX(STAB_CLKS - 1)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clear(!in_wake),
        .inc  (1'b1),
        .full (full)
    );

    // outside wake-up the oscillator is either running or irrelevant
    assign stab_done = !in_wake || full;

    // stabilisation in wake-up can only finish after at least one wake cycle (R10)
    assert_stab_after_wake_R10: assert property (@(posedge clk) disable iff (rst)
        (in_wake && full) |-> $past(mode == M_WAKE));

endmodule

// File: rtl/pms_mode_fsm.sv
module pms_mode_fsm
    import pms_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      idle_req,
    input  logic      pd_req,
    input  logic      irq_pend,
    input  logic      rst_pin,
    input  logic      qual_done,
    input  logic      stab_done,
    output pms_mode_e mode_q,
    output pms_gate_t gate,
    output logic      sfr_load
);
    pms_mode_e mode_d;
    logic      sfr_q;

    always_comb begin
        mode_d = mode_q;
        case (mode_q)
            M_RUN: begin
                if (qual_done)     mode_d = M_RESET;
                else if (pd_req)   mode_d = M_PDOWN;
                else if (idle_req) mode_d = M_IDLE;
            end
            M_IDLE: begin
                if (qual_done)     mode_d = M_RESET;
                else if (irq_pend) mode_d = M_RUN;
            end
            M_PDOWN: begin
                if (rst_pin)       mode_d = M_WAKE;
            end
            M_WAKE: begin
                if (!rst_pin)                   mode_d = M_PDOWN;
                else if (qual_done && stab_done) mode_d = M_RESET;
            end
            M_RESET: begin
                if (!rst_pin)      mode_d = M_RUN;
            end
            default:               mode_d = M_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_RUN;
            sfr_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            sfr_q  <= (mode_d == M_RESET) && (mode_q != M_RESET);
        end
    end

    assign gate     = gate_of(mode_q);
    assign sfr_load = sfr_q;

    assert_idle_wakes_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_IDLE && irq_pend && !qual_done) |=> gate.cpu);

    assert_pd_entry_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RUN && pd_req && !qual_done) |=> (!gate.osc && !gate.per));

    assert_pd_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_PDOWN && !rst_pin) |=> (mode_q == M_PDOWN));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        sfr_load |=> !sfr_load);

    assert_strobe_on_entry_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(gate.rst) |-> sfr_load);

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_RESET && !rst_pin) |=> (mode_q == M_RUN));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int CLKS_PER_MC   = 12,
    parameter int RST_MCYCLES   = 2,
    parameter int OSC_STAB_CLKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic idle_req,
    input  logic pd_req,
    input  logic irq_pend,
    input  logic rst_pin,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic core_rst,
    output logic sfr_load,
    output logic port_force_hi
);
    localparam int RST_CLKS = CLKS_PER_MC * RST_MCYCLES;

    pms_mode_e mode;
    pms_gate_t gate;
    logic      qual_done;
    logic      stab_done;

    pms_rst_qual #(.RST_CLKS(RST_CLKS)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .rst_pin  (rst_pin),
        .mode     (mode),
        .qual_done(qual_done)
    );

    pms_osc_wait #(.STAB_CLKS(OSC_STAB_CLKS)) u_osc (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .stab_done(stab_done)
    );

    pms_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .idle_req (idle_req),
        .pd_req   (pd_req),
        .irq_pend (irq_pend),
        .rst_pin  (rst_pin),
        .qual_done(qual_done),
        .stab_done(stab_done),
        .mode_q   (mode),
        .gate     (gate),
        .sfr_load (sfr_load)
    );

    assign cpu_clk_en    = gate.cpu;
    assign per_clk_en    = gate.per;
    assign osc_en        = gate.osc;
    assign core_rst      = gate.rst;
    assign port_force_hi = rst_pin || gate.rst;

    // internal reset only ever follows a pin that was high (R7)
    assert_reset_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> $past(rst_pin));

    // CPU never clocked while the oscillator is off (R10)
    assert_cpu_needs_osc_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> osc_en);

endmodule

// File: tb/sim_pwr_mode_seq.sv
module sim_pwr_mode_seq;
    localparam int RST_CLKS = 24;
    localparam int STAB     = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic idle_req = 1'b0, pd_req = 1'b0, irq_pend = 1'b0, rst_pin = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, core_rst, sfr_load, port_force_hi;

    always #4 clk = ~clk;

    pwr_mode_seq u0 (
        .clk(clk), .rst(rst), .idle_req(idle_req), .pd_req(pd_req),
        .irq_pend(irq_pend), .rst_pin(rst_pin), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .core_rst(core_rst),
        .sfr_load(sfr_load), .port_force_hi(port_force_hi)
    );

    // behavioural reference: 0 run, 1 idle, 2 power-down, 3 wake-up, 4 reset
    int    m_mode = 0;
    int    m_q    = 0;
    int    m_s    = 0;
    bit    m_sfr  = 0;
    int    n_chk  = 0;
    int    n_bad  = 0;
    int    cyc    = 0;
    bit    done   = 0;
    string tag    = "R1";

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_q = 0; m_s = 0; m_sfr = 0;
        end else begin
            bit qd, sd;
            int nm;
            qd = rst_pin && (m_q >= RST_CLKS - 1);
            sd = (m_mode != 3) || (m_s >= STAB - 1);
            nm = m_mode;
            if (m_mode == 0) begin
                if (qd) nm = 4; else if (pd_req) nm = 2; else if (idle_req) nm = 1;
            end else if (m_mode == 1) begin
                if (qd) nm = 4; else if (irq_pend) nm = 0;
            end else if (m_mode == 2) begin
                if (rst_pin) nm = 3;
            end else if (m_mode == 3) begin
                if (!rst_pin) nm = 2; else if (qd && sd) nm = 4;
            end else begin
                if (!rst_pin) nm = 0;
            end
            m_q   = (!rst_pin || m_mode == 2) ? 0 : ((m_q + 1 > RST_CLKS - 1) ? RST_CLKS - 1 : m_q + 1);
            m_s   = (m_mode != 3) ? 0 : ((m_s + 1 > STAB - 1) ? STAB - 1 : m_s + 1);
            m_sfr = (nm == 4) && (m_mode != 4);
            m_mode = nm;
        end
    end

    task automatic chk(string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at cycle %0d", tag, nm, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            chk("cpu_clk_en", cpu_clk_en, m_mode == 0 || m_mode == 4);
            chk("per_clk_en", per_clk_en, m_mode == 0 || m_mode == 1 || m_mode == 4);
            chk("osc_en", osc_en, m_mode != 2);
            chk("core_rst", core_rst, m_mode == 4);
            chk("sfr_load", sfr_load, m_sfr);
            chk("port_force_hi R6", port_force_hi, rst_pin || m_mode == 4);
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse_idle(); idle_req = 1; wait_cyc(1); idle_req = 0; endtask
    task automatic pulse_pd();   pd_req = 1;   wait_cyc(1); pd_req = 0;   endtask
    task automatic pulse_irq();  irq_pend = 1; wait_cyc(1); irq_pend = 0; endtask

    initial begin
        wait_cyc(3);
        rst = 0;
        tag = "R1"; wait_cyc(3);
        // R2 idle entry, then R12 requests inside idle ignored
        tag = "R2"; pulse_idle(); wait_cyc(4);
        tag = "R12"; pulse_pd(); wait_cyc(2); pulse_idle(); wait_cyc(3);
        // R3 interrupt ends idle
        tag = "R3"; pulse_irq(); wait_cyc(3);
        // R5 simultaneous requests; R4 interrupt in power-down ignored
        tag = "R5"; idle_req = 1; pd_req = 1; wait_cyc(1); idle_req = 0; pd_req = 0; wait_cyc(3);
        tag = "R4"; pulse_irq(); wait_cyc(3); pulse_idle(); wait_cyc(2);
        // R10 early drop returns to power-down, then full wake-up
        tag = "R10"; rst_pin = 1; wait_cyc(10); rst_pin = 0; wait_cyc(4);
        rst_pin = 1; wait_cyc(STAB + 5);
        tag = "R9"; wait_cyc(5); rst_pin = 0; wait_cyc(4);
        // R7 one cycle short of qualification, then qualified
        tag = "R7"; rst_pin = 1; wait_cyc(RST_CLKS - 1); rst_pin = 0; wait_cyc(4);
        rst_pin = 1; wait_cyc(RST_CLKS + 3);
        tag = "R8"; wait_cyc(3); rst_pin = 0; wait_cyc(3);
        // R11 qualified reset ends idle
        tag = "R11"; pulse_idle(); wait_cyc(2); rst_pin = 1; wait_cyc(RST_CLKS + 4);
        rst_pin = 0; wait_cyc(3);
        // R1 synchronous reset from power-down restores run mode
        tag = "R1"; pulse_pd(); wait_cyc(2); rst = 1; wait_cyc(2); rst = 0; wait_cyc(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait_cyc(5000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule